// File: doc/BRIEF.md
# TDM Transmit Slot Source Router

This block decides, slot by slot, where the transmit data of a four-slot time-division audio frame comes from. Software programs an enable mask that marks the slots carrying data, and a DMA mask. An enabled slot whose DMA bit is clear takes its word from a shared transmit FIFO. An enabled slot whose DMA bit is set takes its word from a single-entry holding register dedicated to that slot. A DMA engine keeps each holding register filled in answer to a per-slot request line.

A slot strobe with a slot index tells the router that a slot is starting. In the strobe cycle the router pops the FIFO when the FIFO is the source, or consumes the slot's holding register. It presents the chosen word, registered, on the following cycle for the serializer. It also raises a transmit interrupt whenever the FIFO occupancy is at or below a programmable warning level. A sticky underflow flag records any slot that found its source empty.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset the enable mask and the DMA mask are zero, the warning level is 15, every holding register is empty, and dma_req, underflow, tx_valid and fifo_pop are all low.
- R2: A write selects its target by wr_addr: 0 is the enable mask (wr_data[3:0], bit n for slot n), 1 is the DMA mask (same bit layout), 2 is the warning level (wr_data[3:0]), 3 clears the underflow flag, and 4+n loads the holding register of slot n with wr_data.
- R3: On a strobe for an enabled slot whose DMA bit is clear, with fifo_count nonzero, fifo_pop is high for exactly that cycle and tx_word equals the fifo_rdata of that cycle one cycle later.
- R4: On a strobe for an enabled slot whose DMA bit is set, with its holding register full, fifo_pop stays low and tx_word equals the held value one cycle later.
- R5: On a strobe for a disabled slot, whatever its DMA bit, fifo_pop stays low, tx_word is zero one cycle later, and the underflow flag is not set.
- R6: dma_req[n] is high exactly when slot n is enabled, its DMA bit is set, and its holding register is empty.
- R7: A write to a holding register makes it full in the next cycle. Consuming it makes it empty in the next cycle, so the slot's request rises again. When a write and a consume hit the same slot in one cycle, the old value is transmitted and the new value stays held.
- R8: A strobe on a FIFO-sourced slot with fifo_count zero, or on a DMA-sourced slot with an empty holding register, transmits zero and pops nothing. It also sets underflow on the next cycle, and underflow stays set until a write to address 3.
- R9: tx_irq is high exactly when fifo_count is less than or equal to the warning level.
- R10: tx_valid is high exactly one cycle after each cycle in which slot_strobe is high.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write target address |
| wr_data | input | 16 | Write data |
| fifo_count | input | 5 | Shared FIFO occupancy |
| fifo_rdata | input | 16 | Shared FIFO head word (show-ahead) |
| fifo_pop | output | 1 | Pop the FIFO head this cycle |
| slot_strobe | input | 1 | A slot is starting |
| slot_idx | input | 2 | Index of the starting slot |
| tx_valid | output | 1 | tx_word is valid |
| tx_word | output | 16 | Word for the serializer |
| underflow | output | 1 | Sticky source-empty flag |
| dma_req | output | 4 | Per-slot DMA request |
| tx_irq | output | 1 | FIFO at or below warning level |

## Verification
The assertions check on every cycle that tx_valid follows the strobe, that the FIFO is never popped while empty, that a disabled slot neither pops nor consumes, that a starved slot sends zero, and that the holding registers fill and drain as required. They also check that the underflow flag stays set until it is cleared. Only the bench scenarios can show the register decode and the masks combining into the right source per slot. The same holds for the exact words that reach tx_word, the write-versus-consume collision, and the interrupt compare at its boundaries, from level 0 up to a full FIFO.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_FIFO = 2'd1,
    SRC_HOLD = 2'd2
  } src_e;

  localparam int unsigned ADR_ENABLE = 0;
  localparam int unsigned ADR_DMASEL = 1;
  localparam int unsigned ADR_LEVEL  = 2;
  localparam int unsigned ADR_UFCLR  = 3;
  localparam int unsigned ADR_HOLD0  = 4;

  // source of one slot from its two mask bits; the DMA bit only counts when enabled
  function automatic src_e pick_src(input logic en_bit, input logic dma_bit);
    if (!en_bit)     return SRC_OFF;
    else if (dma_bit) return SRC_HOLD;
    else             return SRC_FIFO;
  endfunction

  // interrupt compare: occupancy at or below the warning level
  function automatic logic level_hit(input int unsigned cnt, input int unsigned lvl);
    return cnt <= lvl;
  endfunction

endpackage

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs #(
  parameter int NSLOTS = 4,
  parameter int DW     = 16,
  parameter int LVLW   = 4,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              uf_event,
  output logic [NSLOTS-1:0] en_mask,
  output logic [NSLOTS-1:0] dma_mask,
  output logic [LVLW-1:0]   level,
  output logic              underflow
);
  import tdm_route_pkg::*;

  logic wr_en_mask, wr_dma_mask, wr_level, uf_clear;

  always_comb begin
    wr_en_mask  = wr_en && (wr_addr == AW'(ADR_ENABLE));
    wr_dma_mask = wr_en && (wr_addr == AW'(ADR_DMASEL));
    wr_level    = wr_en && (wr_addr == AW'(ADR_LEVEL));
    uf_clear    = wr_en && (wr_addr == AW'(ADR_UFCLR));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask   <= '0;
      dma_mask  <= '0;
      level     <= '1;
      underflow <= 1'b0;
    end else begin
      if (wr_en_mask)  en_mask  <= wr_data[NSLOTS-1:0];
      if (wr_dma_mask) dma_mask <= wr_data[NSLOTS-1:0];
      if (wr_level)    level    <= wr_data[LVLW-1:0];
      if (uf_event)      underflow <= 1'b1;
      else if (uf_clear) underflow <= 1'b0;
    end
  end

  // R8: the flag stays set unless a clear arrives without a new event
  p_uf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !uf_clear |=> underflow);
  p_uf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uf_event |=> underflow);

endmodule

// File: rtl/tdm_slot_hold.sv
module tdm_slot_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (load) begin
        full <= 1'b1;
        data <= load_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R7: a write lands and marks the register full
  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> full && data == $past(load_data));
  // R7: consumption without a simultaneous write empties it
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && !load |=> !full);

endmodule

// File: rtl/tdm_word_mux.sv
module tdm_word_mux #(
  parameter int NSLOTS = 4,
  parameter int DW     = 16,
  parameter int CNTW   = 5,
  parameter int IW     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strobe,
  input  logic [IW-1:0]              idx,
  input  logic [NSLOTS-1:0]          en_mask,
  input  logic [NSLOTS-1:0]          dma_mask,
  input  logic [CNTW-1:0]            fifo_count,
  input  logic [DW-1:0]              fifo_rdata,
  input  logic [NSLOTS-1:0]          hold_full,
  input  logic [NSLOTS-1:0][DW-1:0]  hold_data,
  output logic                       fifo_pop,
  output logic [NSLOTS-1:0]          take,
  output logic                       uf_event,
  output logic                       tx_valid,
  output logic [DW-1:0]              tx_word
);
  import tdm_route_pkg::*;

  src_e          src;
  logic          fifo_ok, hold_ok, starved;
  logic [DW-1:0] next_word;

  always_comb begin
    src     = pick_src(en_mask[idx], dma_mask[idx]);
    fifo_ok = fifo_count != '0;
    hold_ok = hold_full[idx];
    starved = strobe && ((src == SRC_FIFO && !fifo_ok) ||
                         (src == SRC_HOLD && !hold_ok));
    fifo_pop = strobe && (src == SRC_FIFO) && fifo_ok;
    uf_event = starved;
    next_word = '0;
    if (strobe && !starved) begin
      case (src)
        SRC_FIFO: next_word = fifo_rdata;
        SRC_HOLD: next_word = hold_data[idx];
        default:  next_word = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NSLOTS; g++) begin : g_take
    assign take[g] = strobe && (idx == IW'(g)) && (src == SRC_HOLD) && hold_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_word  <= '0;
    end else begin
      tx_valid <= strobe;
      tx_word  <= next_word;
    end
  end

  // R10: output qualifier follows the strobe by one cycle
  p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> tx_valid);
  p_novalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !tx_valid);
  // R3 / R8: never pop an empty FIFO
  p_no_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_count != '0);
  // R8: a starved slot transmits zero
  p_starve_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uf_event |=> tx_word == '0);
  // R5: a disabled slot touches no source
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !en_mask[idx] |-> !fifo_pop && take == '0 && !uf_event);
  // R4: at most one slot consumed, never together with a FIFO pop
  p_one_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take, fifo_pop}));

endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
  parameter int NSLOTS = 4,
  parameter int DW     = 16,
  parameter int CNTW   = 5,
  parameter int LVLW   = 4,
  parameter int AW     = 3,
  localparam int IW    = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [CNTW-1:0]   fifo_count,
  input  logic [DW-1:0]     fifo_rdata,
  output logic              fifo_pop,
  input  logic              slot_strobe,
  input  logic [IW-1:0]     slot_idx,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_word,
  output logic              underflow,
  output logic [NSLOTS-1:0] dma_req,
  output logic              tx_irq
);
  import tdm_route_pkg::*;

  logic [NSLOTS-1:0]         en_mask, dma_mask, hold_full, take, hold_load;
  logic [NSLOTS-1:0][DW-1:0] hold_data;
  logic [LVLW-1:0]           level;
  logic                      uf_event;

  tdm_cfg_regs #(.NSLOTS(NSLOTS), .DW(DW), .LVLW(LVLW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .uf_event(uf_event), .en_mask(en_mask), .dma_mask(dma_mask), .level(level),
    .underflow(underflow)
  );

  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    assign hold_load[g] = wr_en && (wr_addr == AW'(ADR_HOLD0 + g));
    tdm_slot_hold #(.DW(DW)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(hold_load[g]), .load_data(wr_data),
      .take(take[g]), .full(hold_full[g]), .data(hold_data[g])
    );
    assign dma_req[g] = (pick_src(en_mask[g], dma_mask[g]) == SRC_HOLD) && !hold_full[g];

    // R7: after consumption without refill the request rises again
    p_req_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take[g] && !hold_load[g] && en_mask[g] && dma_mask[g] && !wr_en |=> dma_req[g]);
  end

  tdm_word_mux #(.NSLOTS(NSLOTS), .DW(DW), .CNTW(CNTW), .IW(IW)) u_mux (
    .clk(clk), .rst_n(rst_n), .strobe(slot_strobe), .idx(slot_idx),
    .en_mask(en_mask), .dma_mask(dma_mask), .fifo_count(fifo_count),
    .fifo_rdata(fifo_rdata), .hold_full(hold_full), .hold_data(hold_data),
    .fifo_pop(fifo_pop), .take(take), .uf_event(uf_event),
    .tx_valid(tx_valid), .tx_word(tx_word)
  );

  assign tx_irq = level_hit(32'(fifo_count), 32'(level));

  // R6: no request for a slot that is disabled
  p_req_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req & ~en_mask) == '0);

endmodule

// File: tb/tb_tdm_slot_router.sv
module tb_tdm_slot_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  fifo_count = '0;
  logic [15:0] fifo_rdata = '0;
  logic        fifo_pop;
  logic        slot_strobe = 1'b0;
  logic [1:0]  slot_idx = '0;
  logic        tx_valid;
  logic [15:0] tx_word;
  logic        underflow;
  logic [3:0]  dma_req;
  logic        tx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tdm_slot_router dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_count(fifo_count), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .slot_strobe(slot_strobe), .slot_idx(slot_idx), .tx_valid(tx_valid),
    .tx_word(tx_word), .underflow(underflow), .dma_req(dma_req), .tx_irq(tx_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one slot: pop checked in the strobe cycle, word/valid/flag one cycle later
  task automatic slot(input string tag, input int i, input int exp_pop,
                      input int exp_word, input int exp_uf);
    @(negedge clk);
    slot_strobe = 1'b1; slot_idx = 2'(i);
    #1 chk({tag, " pop"}, int'(fifo_pop), exp_pop);
    @(negedge clk);
    slot_strobe = 1'b0;
    chk({tag, " valid R10"}, int'(tx_valid), 1);
    chk({tag, " word"}, int'(tx_word), exp_word);
    chk({tag, " underflow"}, int'(underflow), exp_uf);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fifo_count = 5'd15;
    #1;
    chk("R1 dma_req", int'(dma_req), 0);
    chk("R1 underflow", int'(underflow), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 fifo_pop", int'(fifo_pop), 0);
    chk("R1 level 15 hit", int'(tx_irq), 1);
    fifo_count = 5'd16;
    #1 chk("R1 level 15 above", int'(tx_irq), 0);
    @(negedge clk);
    chk("R10 idle no valid", int'(tx_valid), 0);
  endtask

  task automatic t_disabled();
    fifo_count = 5'd5; fifo_rdata = 16'h7777;
    wr(1, 'hF);          // DMA bits set, enables still clear
    chk("R6 no req when disabled", int'(dma_req), 0);
    slot("R5 disabled slot2", 2, 0, 0, 0);
  endtask

  task automatic t_fifo();
    wr(1, 0);
    wr(0, 'b0101);
    fifo_count = 5'd4; fifo_rdata = 16'hA5A5;
    slot("R3 fifo slot0", 0, 1, 'hA5A5, 0);
    fifo_rdata = 16'h1234;
    slot("R3 fifo slot2", 2, 1, 'h1234, 0);
    slot("R5 masked slot1", 1, 0, 0, 0);
  endtask

  task automatic t_dma();
    wr(0, 'hF);
    wr(1, 'b1010);
    chk("R6 req pattern", int'(dma_req), 'b1010);
    wr(5, 'hBEEF);      // R2: address 4+1 is slot 1
    chk("R7 fill drops req", int'(dma_req), 'b1000);
    fifo_count = 5'd3; fifo_rdata = 16'h0F0F;
    slot("R4 dma slot1", 1, 0, 'hBEEF, 0);
    chk("R7 req back after consume", int'(dma_req), 'b1010);
    slot("R3 fifo slot0 mixed", 0, 1, 'h0F0F, 0);
  endtask

  task automatic t_underflow();
    fifo_count = 5'd0;
    slot("R8 fifo empty slot0", 0, 0, 0, 1);
    wr(3, 0);
    chk("R8 clear", int'(underflow), 0);
    fifo_count = 5'd2;
    slot("R8 hold empty slot3", 3, 0, 0, 1);
    slot("R8 sticky after good slot", 2, 1, 'h0F0F, 1);
    wr(3, 0);
    chk("R8 clear again", int'(underflow), 0);
  endtask

  task automatic t_collide();
    wr(7, 'h1111);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 16'h2222;
    slot_strobe = 1'b1; slot_idx = 2'd3;
    #1 chk("R7 collide no pop", int'(fifo_pop), 0);
    @(negedge clk);
    wr_en = 1'b0; slot_strobe = 1'b0;
    chk("R7 collide old word", int'(tx_word), 'h1111);
    chk("R7 collide stays full", int'(dma_req[3]), 0);
    slot("R7 new word held", 3, 0, 'h2222, 0);
    chk("R7 empty after", int'(dma_req[3]), 1);
  endtask

  task automatic t_irq();
    wr(2, 4);
    fifo_count = 5'd4; #1 chk("R9 equal", int'(tx_irq), 1);
    fifo_count = 5'd5; #1 chk("R9 above", int'(tx_irq), 0);
    fifo_count = 5'd0; #1 chk("R9 empty", int'(tx_irq), 1);
    wr(2, 'hF0);        // only the low four bits count: level 0
    fifo_count = 5'd0; #1 chk("R9 level0 empty", int'(tx_irq), 1);
    fifo_count = 5'd1; #1 chk("R9 level0 one", int'(tx_irq), 0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_fifo();
    t_dma();
    t_underflow();
    t_collide();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule